// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block runs the fixed bus sequence an 8-bit CPU performs when it enters an interrupt service routine. At an instruction boundary it accepts either a maskable hardware request or a software-interrupt trigger. It saves the running context on a post-decrementing stack and reads a two-byte vector. After one idle bus cycle it prefetches the first opcode bytes of the service routine into a small instruction queue. It then hands the new PC, stack pointer, condition codes and queue back to the core with a one-cycle completion pulse.

The block drives a single memory port that makes at most one access per clock. Memory answers a read in the same cycle. The index high byte is not part of the saved frame. The core that instantiates this sequencer must save that byte in software if the routine modifies it.

Top module: `irq_entry_seq`

## Requirements
- R1: After acceptance the block makes five writes, one per cycle, at addresses SP, SP-1, SP-2, SP-3, SP-4. The data are PC[7:0], PC[15:8], X, A and CCR, in that order. `sp_out` ends at SP-5.
- R2: The CCR byte written to the stack is `ccr_in` unchanged. `ccr_out` equals `ccr_in` with bit 3 (the interrupt mask) set and all other bits unchanged.
- R3: A complete entry performs exactly five write cycles. No other byte of context (in particular the index high byte) is stored.
- R4: After the pushes the block reads the vector high byte at the selected vector address V and then the low byte at V+1. `pc_out` equals {high, low}.
- R5: The cycle right after the vector low read has no memory access (`bus_en` low). The cycle before it and the cycle after it both have an access.
- R6: After the idle cycle the block reads three bytes at `pc_out`, `pc_out`+1 and `pc_out`+2. `queue_out[7:0]` holds the first byte, `[15:8]` the second and `[23:16]` the third.
- R7: A hardware request is accepted only at a clock edge where `insn_bound` is high and `ccr_in` bit 3 is clear. Otherwise it has no effect: `busy` and `bus_en` stay low.
- R8: A software trigger with `insn_bound` high is accepted whatever the value of `ccr_in` bit 3, and the block uses `swi_vec_addr`. When a software trigger and a hardware request arrive together, the software trigger wins.
- R9: `busy` is high for the 12 cycles after the accepting edge. `done` is high only in the last of these cycles, and the new PC, SP, CCR and queue are valid in that cycle.
- R10: Triggers that arrive while `busy` is high are ignored: no second sequence follows the completion pulse.
- R11: While reset is active and just after it, `busy`, `done`, `bus_en` and `bus_we` are low and `pc_out`, `sp_out`, `ccr_out` and `queue_out` are zero.
- R12: `bus_we` is never high without `bus_en`, and `bus_en` is low whenever `busy` is low. Vector and prefetch cycles are reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| insn_bound | input | 1 | One-cycle instruction boundary strobe |
| hw_irq | input | 1 | Maskable hardware interrupt request |
| swi_trig | input | 1 | Software interrupt trigger from decode |
| pc_in | input | 16 | Return PC to save |
| x_in | input | 8 | X register to save |
| a_in | input | 8 | Accumulator to save |
| ccr_in | input | 8 | Condition codes; bit 3 is the mask |
| sp_in | input | 16 | Current stack pointer |
| hw_vec_addr | input | 16 | Vector address for the hardware request |
| swi_vec_addr | input | 16 | Vector address for the software trigger |
| bus_addr | output | 16 | Memory address |
| bus_wdata | output | 8 | Memory write data |
| bus_rdata | input | 8 | Memory read data, valid in the same cycle |
| bus_en | output | 1 | Memory access in this cycle |
| bus_we | output | 1 | Access is a write |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| pc_out | output | 16 | Service routine entry address |
| sp_out | output | 16 | Stack pointer after the pushes |
| ccr_out | output | 8 | Condition codes with mask set |
| queue_out | output | 24 | Prefetched opcode bytes, first byte lowest |

## Verification
The bench traces every bus cycle of an entry and compares the push frame byte by byte. A design that swapped the PC halves or saved an extra index byte would show a wrong address, wrong data or a sixth write. The stacked CCR is compared against the pre-entry value, which exposes a mask that is set before the CCR push. The bench checks that the idle cycle falls after the vector low read, so a missing or misplaced gap would move the prefetch addresses. Masked hardware requests, requests off the boundary, software triggers under mask, simultaneous triggers and triggers during a running sequence probe the acceptance logic, where an error either starts a spurious sequence or takes the wrong vector.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
   localparam int unsigned PUSH_BYTES = 5;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PUSH,
      ST_VHI,
      ST_VLO,
      ST_GAP,
      ST_FETCH,
      ST_DONE
   } seq_st_e;
endpackage

// File: rtl/irq_entry_arb.sv
module irq_entry_arb #(
   parameter int unsigned AW   = 16,
   parameter int unsigned DW   = 8,
   parameter int unsigned IBIT = 3
) (
   input  logic          idle,
   input  logic          insn_bound,
   input  logic          hw_irq,
   input  logic          swi_trig,
   input  logic [DW-1:0] ccr_in,
   input  logic [AW-1:0] hw_vec_addr,
   input  logic [AW-1:0] swi_vec_addr,
   output logic          start,
   output logic [AW-1:0] vec_sel
);
   logic hw_ok;

   assign hw_ok   = hw_irq & ~ccr_in[IBIT];
   assign start   = idle & insn_bound & (swi_trig | hw_ok);
   assign vec_sel = swi_trig ? swi_vec_addr : hw_vec_addr;
endmodule

// File: rtl/irq_entry_queue.sv
module irq_entry_queue #(
   parameter int unsigned DW    = 8,
   parameter int unsigned DEPTH = 3,
   localparam int unsigned QW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ld,
   input  logic [QW-1:0]       idx,
   input  logic [DW-1:0]       din,
   output logic [DEPTH*DW-1:0] q_flat
);
   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      logic [DW-1:0] slot_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            slot_q <= '0;
         end else if (ld && (idx == QW'(g))) begin
            slot_q <= din;
         end
      end
      assign q_flat[g*DW +: DW] = slot_q;
   end
endmodule

// File: rtl/irq_entry_core.sv
module irq_entry_core
   import irq_entry_pkg::*;
#(
   parameter int unsigned AW    = 16,
   parameter int unsigned DW    = 8,
   parameter int unsigned IBIT  = 3,
   parameter int unsigned QDEPTH = 3,
   localparam int unsigned CMAX = (QDEPTH > PUSH_BYTES) ? QDEPTH : PUSH_BYTES,
   localparam int unsigned CW   = $clog2(CMAX),
   localparam int unsigned QW   = (QDEPTH > 1) ? $clog2(QDEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [AW-1:0] vec_sel,
   input  logic [AW-1:0] pc_in,
   input  logic [DW-1:0] x_in,
   input  logic [DW-1:0] a_in,
   input  logic [DW-1:0] ccr_in,
   input  logic [AW-1:0] sp_in,
   input  logic [DW-1:0] bus_rdata,
   output logic [AW-1:0] bus_addr,
   output logic [DW-1:0] bus_wdata,
   output logic          bus_en,
   output logic          bus_we,
   output logic          q_ld,
   output logic [QW-1:0] q_idx,
   output logic [AW-1:0] newpc,
   output logic [AW-1:0] sp_cur,
   output logic [DW-1:0] ccr_cur,
   output seq_st_e       st
);
   seq_st_e       st_q;
   logic [CW-1:0] cnt_q;
   logic [AW-1:0] pc_q, sp_q, vec_q, newpc_q;
   logic [DW-1:0] x_q, a_q, ccr_q;
   logic [DW-1:0] push_data;

   always_comb begin
      case (cnt_q)
         CW'(0):  push_data = pc_q[DW-1:0];
         CW'(1):  push_data = pc_q[AW-1:DW];
         CW'(2):  push_data = x_q;
         CW'(3):  push_data = a_q;
         default: push_data = ccr_q;
      endcase
   end

   always_comb begin
      bus_en    = 1'b0;
      bus_we    = 1'b0;
      bus_addr  = '0;
      bus_wdata = '0;
      q_ld      = 1'b0;
      case (st_q)
         ST_PUSH: begin
            bus_en    = 1'b1;
            bus_we    = 1'b1;
            bus_addr  = sp_q;
            bus_wdata = push_data;
         end
         ST_VHI: begin
            bus_en   = 1'b1;
            bus_addr = vec_q;
         end
         ST_VLO: begin
            bus_en   = 1'b1;
            bus_addr = vec_q + AW'(1);
         end
         ST_FETCH: begin
            bus_en   = 1'b1;
            bus_addr = newpc_q + AW'(cnt_q);
            q_ld     = 1'b1;
         end
         default: ;
      endcase
   end

   assign q_idx   = QW'(cnt_q);
   assign newpc   = newpc_q;
   assign sp_cur  = sp_q;
   assign ccr_cur = ccr_q;
   assign st      = st_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         cnt_q   <= '0;
         pc_q    <= '0;
         sp_q    <= '0;
         vec_q   <= '0;
         newpc_q <= '0;
         x_q     <= '0;
         a_q     <= '0;
         ccr_q   <= '0;
      end else begin
         case (st_q)
            ST_IDLE: if (start) begin
               st_q  <= ST_PUSH;
               cnt_q <= '0;
               pc_q  <= pc_in;
               sp_q  <= sp_in;
               vec_q <= vec_sel;
               x_q   <= x_in;
               a_q   <= a_in;
               ccr_q <= ccr_in;
            end
            ST_PUSH: begin
               sp_q <= sp_q - AW'(1);
               if (cnt_q == CW'(PUSH_BYTES - 1)) begin
                  ccr_q[IBIT] <= 1'b1;
                  cnt_q       <= '0;
                  st_q        <= ST_VHI;
               end else begin
                  cnt_q <= cnt_q + CW'(1);
               end
            end
            ST_VHI: begin
               newpc_q[AW-1:DW] <= bus_rdata;
               st_q             <= ST_VLO;
            end
            ST_VLO: begin
               newpc_q[DW-1:0] <= bus_rdata;
               st_q            <= ST_GAP;
            end
            ST_GAP: st_q <= ST_FETCH;
            ST_FETCH: begin
               if (cnt_q == CW'(QDEPTH - 1)) begin
                  cnt_q <= '0;
                  st_q  <= ST_DONE;
               end else begin
                  cnt_q <= cnt_q + CW'(1);
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
   import irq_entry_pkg::*;
#(
   parameter int unsigned AW     = 16,
   parameter int unsigned DW     = 8,
   parameter int unsigned IBIT   = 3,
   parameter int unsigned QDEPTH = 3,
   localparam int unsigned QW    = (QDEPTH > 1) ? $clog2(QDEPTH) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 insn_bound,
   input  logic                 hw_irq,
   input  logic                 swi_trig,
   input  logic [AW-1:0]        pc_in,
   input  logic [DW-1:0]        x_in,
   input  logic [DW-1:0]        a_in,
   input  logic [DW-1:0]        ccr_in,
   input  logic [AW-1:0]        sp_in,
   input  logic [AW-1:0]        hw_vec_addr,
   input  logic [AW-1:0]        swi_vec_addr,
   output logic [AW-1:0]        bus_addr,
   output logic [DW-1:0]        bus_wdata,
   input  logic [DW-1:0]        bus_rdata,
   output logic                 bus_en,
   output logic                 bus_we,
   output logic                 busy,
   output logic                 done,
   output logic [AW-1:0]        pc_out,
   output logic [AW-1:0]        sp_out,
   output logic [DW-1:0]        ccr_out,
   output logic [QDEPTH*DW-1:0] queue_out
);
   if (AW != 2 * DW) begin : g_bad_aw
      $error("irq_entry_seq: AW must be twice DW");
   end
   if (IBIT >= DW) begin : g_bad_ibit
      $error("irq_entry_seq: IBIT outside CCR");
   end
   if (QDEPTH < 2 || QDEPTH > 8) begin : g_bad_q
      $error("irq_entry_seq: QDEPTH must be 2..8");
   end

   seq_st_e       st_w;
   logic          start_w;
   logic [AW-1:0] vec_w;
   logic          q_ld_w;
   logic [QW-1:0] q_idx_w;

   irq_entry_arb #(.AW(AW), .DW(DW), .IBIT(IBIT)) u_arb (
      .idle         (st_w == ST_IDLE),
      .insn_bound   (insn_bound),
      .hw_irq       (hw_irq),
      .swi_trig     (swi_trig),
      .ccr_in       (ccr_in),
      .hw_vec_addr  (hw_vec_addr),
      .swi_vec_addr (swi_vec_addr),
      .start        (start_w),
      .vec_sel      (vec_w)
   );

   irq_entry_core #(.AW(AW), .DW(DW), .IBIT(IBIT), .QDEPTH(QDEPTH)) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start_w),
      .vec_sel   (vec_w),
      .pc_in     (pc_in),
      .x_in      (x_in),
      .a_in      (a_in),
      .ccr_in    (ccr_in),
      .sp_in     (sp_in),
      .bus_rdata (bus_rdata),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_en    (bus_en),
      .bus_we    (bus_we),
      .q_ld      (q_ld_w),
      .q_idx     (q_idx_w),
      .newpc     (pc_out),
      .sp_cur    (sp_out),
      .ccr_cur   (ccr_out),
      .st        (st_w)
   );

   irq_entry_queue #(.DW(DW), .DEPTH(QDEPTH)) u_queue (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld     (q_ld_w),
      .idx    (q_idx_w),
      .din    (bus_rdata),
      .q_flat (queue_out)
   );

   assign busy = (st_w != ST_IDLE);
   assign done = (st_w == ST_DONE);
endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk
   import irq_entry_pkg::*;
#(
   parameter int unsigned AW   = 16,
   parameter int unsigned DW   = 8,
   parameter int unsigned IBIT = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic          insn_bound,
   input logic          busy,
   input logic          done,
   input logic          bus_en,
   input logic          bus_we,
   input logic [AW-1:0] bus_addr,
   input logic [DW-1:0] ccr_out,
   input seq_st_e       st
);
   // R1: consecutive pushes walk down the stack
   a_r1_push_descends: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && $past(bus_we)) |-> bus_addr == $past(bus_addr) - AW'(1));
   // R2: mask set when the new context is handed back
   a_r2_mask_on_done: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ccr_out[IBIT]);
   // R4: low vector byte follows high byte
   a_r4_vec_lo_next: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_VLO) |-> (bus_en && !bus_we && bus_addr == $past(bus_addr) + AW'(1)));
   // R5: idle bus cycle after the vector
   a_r5_gap_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_GAP) |-> !bus_en);
   // R7 / R8: a sequence starts only from a boundary
   a_r8_start_at_bound: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(insn_bound));
   // R9: completion lasts one cycle and ends the sequence
   a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy));
   // R12: single access discipline
   a_r12_we_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
      bus_we |-> bus_en);
   a_r12_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !bus_en);
endmodule

bind irq_entry_seq irq_entry_chk #(.AW(AW), .DW(DW), .IBIT(IBIT)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .insn_bound (insn_bound),
   .busy       (busy),
   .done       (done),
   .bus_en     (bus_en),
   .bus_we     (bus_we),
   .bus_addr   (bus_addr),
   .ccr_out    (ccr_out),
   .st         (st_w)
);

// File: tb/irq_entry_seq_tb.sv
module irq_entry_seq_tb_top;
   localparam int TL = 14;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        insn_bound = 1'b0, hw_irq = 1'b0, swi_trig = 1'b0;
   logic [15:0] pc_in = '0, sp_in = '0;
   logic [7:0]  x_in = '0, a_in = '0, ccr_in = '0;
   logic [15:0] hw_vec_addr = 16'h0380, swi_vec_addr = 16'h0390;
   logic [15:0] bus_addr, pc_out, sp_out;
   logic [7:0]  bus_wdata, bus_rdata, ccr_out;
   logic        bus_en, bus_we, busy, done;
   logic [23:0] queue_out;

   logic [7:0] mem [1024];

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   logic        t_en [TL];
   logic        t_we [TL];
   logic [15:0] t_addr [TL];
   logic [7:0]  t_wd [TL];
   logic        t_busy [TL];
   logic        t_done [TL];
   logic [15:0] c_pc, c_sp;
   logic [7:0]  c_ccr;
   logic [23:0] c_q;

   always #10 clk = ~clk;

   irq_entry_seq dut_i (
      .clk(clk), .rst_n(rst_n), .insn_bound(insn_bound), .hw_irq(hw_irq),
      .swi_trig(swi_trig), .pc_in(pc_in), .x_in(x_in), .a_in(a_in),
      .ccr_in(ccr_in), .sp_in(sp_in), .hw_vec_addr(hw_vec_addr),
      .swi_vec_addr(swi_vec_addr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bus_en(bus_en), .bus_we(bus_we), .busy(busy),
      .done(done), .pc_out(pc_out), .sp_out(sp_out), .ccr_out(ccr_out),
      .queue_out(queue_out)
   );

   assign bus_rdata = mem[bus_addr[9:0]];
   always @(posedge clk) if (bus_we) mem[bus_addr[9:0]] <= bus_wdata;

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic trace(input logic hw, input logic swi, input logic bnd,
                        input int again);
      @(negedge clk);
      insn_bound = bnd; hw_irq = hw; swi_trig = swi;
      for (int i = 0; i < TL; i++) begin
         @(negedge clk);
         insn_bound = (i == again); hw_irq = (i == again); swi_trig = (i == again);
         t_en[i] = bus_en; t_we[i] = bus_we; t_addr[i] = bus_addr;
         t_wd[i] = bus_wdata; t_busy[i] = busy; t_done[i] = done;
         if (done) begin
            c_pc = pc_out; c_sp = sp_out; c_ccr = ccr_out; c_q = queue_out;
         end
      end
      insn_bound = 1'b0; hw_irq = 1'b0; swi_trig = 1'b0;
   endtask

   task automatic verify_entry(input logic [15:0] vec, input logic [15:0] isr,
                               input logic [23:0] qexp);
      logic [7:0] frame [5];
      int nw = 0;
      frame[0] = pc_in[7:0]; frame[1] = pc_in[15:8];
      frame[2] = x_in; frame[3] = a_in; frame[4] = ccr_in;
      for (int k = 0; k < 5; k++) begin
         chk(t_en[k] && t_we[k], "R12", {t_en[k], t_we[k]}, 2'b11);
         chk(t_addr[k] == sp_in - 16'(k), "R1", t_addr[k], sp_in - 16'(k));
         chk(t_wd[k] == frame[k], (k == 4) ? "R2" : "R1", t_wd[k], frame[k]);
      end
      for (int k = 0; k < TL; k++) nw += int'(t_we[k]);
      chk(nw == 5, "R3", nw, 5);
      chk(t_en[5] && !t_we[5] && t_addr[5] == vec, "R4", t_addr[5], vec);
      chk(t_en[6] && !t_we[6] && t_addr[6] == vec + 16'd1, "R4", t_addr[6], vec + 16'd1);
      chk(!t_en[7] && t_en[6] && t_en[8], "R5", {t_en[6], t_en[7], t_en[8]}, 3'b101);
      for (int k = 0; k < 3; k++)
         chk(t_en[8+k] && !t_we[8+k] && t_addr[8+k] == isr + 16'(k), "R6",
             t_addr[8+k], isr + 16'(k));
      for (int k = 0; k < TL; k++) begin
         chk(t_busy[k] == (k < 12), "R9", t_busy[k], k < 12);
         chk(t_done[k] == (k == 11), "R9", t_done[k], k == 11);
      end
      chk(c_pc == isr, "R4", c_pc, isr);
      chk(c_sp == sp_in - 16'd5, "R1", c_sp, sp_in - 16'd5);
      chk(c_ccr == (ccr_in | 8'h08), "R2", c_ccr, ccr_in | 8'h08);
      chk(c_q == qexp, "R6", c_q, qexp);
   endtask

   task automatic check_quiet(input string req);
      int act = 0;
      for (int k = 0; k < TL; k++) act += int'(t_busy[k]) + int'(t_en[k]);
      chk(act == 0, req, act, 0);
   endtask

   task automatic t_reset;
      chk(!busy && !done && !bus_en && !bus_we, "R11", {busy, done, bus_en, bus_we}, 0);
      chk(pc_out == 0 && sp_out == 0 && ccr_out == 0 && queue_out == 0, "R11",
          {pc_out, sp_out}, 0);
   endtask

   task automatic t_hw_entry;
      pc_in = 16'h1234; x_in = 8'h56; a_in = 8'h78; ccr_in = 8'h60; sp_in = 16'h03F0;
      trace(1'b1, 1'b0, 1'b1, -1);
      verify_entry(16'h0380, 16'h0120, 24'hC3B2A1);
   endtask

   task automatic t_hw_masked;
      ccr_in = 8'h68;
      trace(1'b1, 1'b0, 1'b1, -1);
      check_quiet("R7");
      ccr_in = 8'h60;
      trace(1'b1, 1'b0, 1'b0, -1);
      check_quiet("R7");
   endtask

   task automatic t_swi_masked;
      pc_in = 16'hBEEF; x_in = 8'h0F; a_in = 8'hF0; ccr_in = 8'hE9; sp_in = 16'h02FF;
      trace(1'b0, 1'b1, 1'b1, -1);
      verify_entry(16'h0390, 16'h0150, 24'hF6E5D4);
   endtask

   task automatic t_swi_wins;
      pc_in = 16'h4001; x_in = 8'h11; a_in = 8'h22; ccr_in = 8'h40; sp_in = 16'h0200;
      trace(1'b1, 1'b1, 1'b1, -1);
      chk(t_addr[5] == 16'h0390, "R8", t_addr[5], 16'h0390);
      verify_entry(16'h0390, 16'h0150, 24'hF6E5D4);
   endtask

   task automatic t_busy_ignore;
      pc_in = 16'h0A0B; x_in = 8'h33; a_in = 8'h44; ccr_in = 8'h00; sp_in = 16'h03A0;
      trace(1'b1, 1'b0, 1'b1, 3);
      verify_entry(16'h0380, 16'h0120, 24'hC3B2A1);
      chk(!t_busy[12] && !t_busy[13], "R10", {t_busy[12], t_busy[13]}, 0);
   endtask

   initial begin
      for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
      mem[10'h380] = 8'h01; mem[10'h381] = 8'h20;
      mem[10'h390] = 8'h01; mem[10'h391] = 8'h50;
      mem[10'h120] = 8'hA1; mem[10'h121] = 8'hB2; mem[10'h122] = 8'hC3;
      mem[10'h150] = 8'hD4; mem[10'h151] = 8'hE5; mem[10'h152] = 8'hF6;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_hw_entry();
      t_hw_masked();
      t_swi_masked();
      t_swi_wins();
      t_busy_ignore();
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end
endmodule